// File: doc/BRIEF.md
# PWM Event Table Builder

This block turns one colour's set of sixteen 8-bit brightness levels into the switch-off event table that a row-scan PWM player walks through during a colour period. Each table entry holds a column enable mask and the compare value at which the player moves on to the following entry. Entry 0 switches on every lit channel. Each later entry drops the channels whose level has just been reached. Channels that share a level are dropped by one common event, so the table has one event per distinct level.

A one-cycle `start` latches the level bank. The builder then writes all 68 table bytes through a write port, one byte per cycle, in ascending address order. Channels at level 0 never light. Channels at level 255 are never switched off. Entries that follow the last real event repeat the final column mask and carry a zero compare value and a clear flag, which tells the player to stop. A one-cycle `done` follows the last write. A `start` that arrives during a build is ignored.

Top module: `pwm_evt_table`

## Requirements
- R1: After reset, `wr_en` and `done` are low and stay low until a `start` is seen while idle.
- R2: A `start` sampled high while idle is followed, from the next cycle on, by exactly 68 consecutive cycles with `wr_en` high, and `wr_addr` steps 0, 1, ..., 67.
- R3: Entry k occupies addresses 4k..4k+3. Byte 4k is the column mask for channels 0-7 (bit i = channel i). Byte 4k+1 is the mask for channels 8-15 (bit i = channel 8+i). Byte 4k+2 is the compare value. Byte 4k+3 is the flag.
- R4: Entry 0's column mask has a bit set for exactly the channels whose latched level is nonzero.
- R5: For k >= 1, entry k's mask is entry k-1's mask with every channel cleared whose level equals entry k-1's nonzero compare value. Channels with equal levels leave in the same entry.
- R6: Entry k's compare value is the smallest level below 255 among the channels enabled in entry k, and its flag is 1. If no such channel exists, the compare value is 0 and the flag is 0, and every later entry repeats the same mask.
- R7: A channel at level 255 stays set in the mask of every entry 0..16.
- R8: `done` is high for exactly one cycle: the cycle right after the write to address 67. `wr_en` is low in that cycle, and a `start` in that cycle is accepted.
- R9: A `start` during a build has no effect. The write sequence continues without a break or restart, and the table reflects only the levels latched at the accepted `start`.
- R10: Changes on `levels` after the accepted `start` do not affect the table being written.
- R11: With sixteen distinct levels in 1..254, entries 0..15 each carry a flag of 1, and entry 16 has an empty mask, compare 0 and flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Build request, honoured only while idle |
| levels | input | 128 | Brightness bank, channel i in bits 8i+7..8i |
| wr_en | output | 1 | Table byte write strobe |
| wr_addr | output | 7 | Table byte address, 0..67 |
| wr_data | output | 8 | Table byte value |
| done | output | 1 | One-cycle completion pulse |

## Verification
An active mask that fails to clear a channel, or clears too many, shows up in the column bytes of the very next entry, at most four cycles after the faulty update. A wrong minimum search shows up one or two bytes earlier, in the compare byte or the flag byte of the current entry. A wrongly latched level shows in entry 0's bytes within the first four write cycles. A sequencing fault in the address or entry counters shows on `wr_addr`, `wr_en` or `done` in the cycle where it happens. Level sets with ties, zeros, 255s, all-distinct values, back-to-back starts and mid-build disturbances each push these paths toward a different edge.

// File: rtl/pwm_evt_table.sv
module pwm_evt_table #(
  parameter int NCH = 16,
  localparam int AW = $clog2((NCH + 1) * (NCH / 8 + 2))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NCH*8-1:0] levels,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             done
);
  localparam int CB     = NCH / 8;
  localparam int EB     = CB + 2;
  localparam int NBYTES = (NCH + 1) * EB;
  localparam int BW     = $clog2(EB);

  logic           busy, done_q;
  logic [AW-1:0]  wa;
  logic [BW-1:0]  bsel;
  logic [NCH-1:0] act, hit;
  logic [7:0]     lv [NCH];
  logic [7:0]     min_v, byte_o;
  logic           min_ok;

  always_comb begin
    min_v  = 8'hFF;
    min_ok = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (act[i] && lv[i] != 8'hFF && (!min_ok || lv[i] < min_v)) begin
        min_v  = lv[i];
        min_ok = 1'b1;
      end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit[g] = act[g] & min_ok & (lv[g] == min_v);
  end

  always_comb begin
    byte_o = '0;
    for (int c = 0; c < CB; c++)
      if (bsel == BW'(c)) byte_o = act[c*8 +: 8];
    if (bsel == BW'(CB))     byte_o = min_ok ? min_v : 8'h00;
    if (bsel == BW'(CB + 1)) byte_o = {7'b0, min_ok};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      wa     <= '0;
      bsel   <= '0;
      act    <= '0;
      for (int i = 0; i < NCH; i++) lv[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          wa   <= '0;
          bsel <= '0;
          for (int i = 0; i < NCH; i++) begin
            lv[i]  <= levels[8*i +: 8];
            act[i] <= |levels[8*i +: 8];
          end
        end
      end else begin
        wa <= wa + 1'b1;
        if (bsel == BW'(EB - 1)) begin
          bsel <= '0;
          act  <= act & ~hit;
        end else begin
          bsel <= bsel + 1'b1;
        end
        if (wa == AW'(NBYTES - 1)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign wr_en   = busy;
  assign wr_addr = wa;
  assign wr_data = byte_o;
  assign done    = done_q;
endmodule

// File: rtl/pwm_evt_table_chk.sv
module pwm_evt_table_chk #(
  parameter int NCH = 16,
  localparam int AW = $clog2((NCH + 1) * (NCH / 8 + 2))
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          done
);
  localparam int EB = NCH / 8 + 2;
  localparam int NB = (NCH + 1) * EB;

  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> wr_addr == '0);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!wr_en || wr_addr == AW'($past(wr_addr) + 1'b1)));

  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < NB);

  a_r9_no_break: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != AW'(NB - 1)) |=> wr_en);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_en && $past(wr_en) && $past(wr_addr) == AW'(NB - 1)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_flag_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) % EB) == EB - 1) |-> wr_data <= 8'd1);

  a_r6_flag_matches_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) % EB) == EB - 1) |-> ((wr_data == 8'd0) == ($past(wr_data) == 8'd0)));

  a_r11_last_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= NB - 2) |-> wr_data == 8'd0);
endmodule

bind pwm_evt_table pwm_evt_table_chk #(.NCH(NCH)) chk_i (.*);

// File: tb/pwm_evt_table_tb_top.sv
module pwm_evt_table_tb_top;
  localparam int NCH = 16;
  localparam int NB  = 68;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [NCH*8-1:0] levels = '0;
  logic             wr_en, done;
  logic [6:0]       wr_addr;
  logic [7:0]       wr_data;

  pwm_evt_table #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .levels(levels),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";
  logic [7:0] tbl [NB];
  bit m_busy = 1'b0, m_done = 1'b0;
  int m_idx = 0;

  function automatic void build(input logic [NCH*8-1:0] v);
    int d[$];
    int val[NCH];
    logic [15:0] m;
    for (int ch = 0; ch < NCH; ch++) begin
      bit seen = 1'b0;
      val[ch] = int'(v[8*ch +: 8]);
      foreach (d[j]) if (d[j] == val[ch]) seen = 1'b1;
      if (val[ch] > 0 && val[ch] < 255 && !seen) d.push_back(val[ch]);
    end
    d.sort();
    for (int ch = 0; ch < NCH; ch++) m[ch] = (val[ch] != 0);
    for (int k = 0; k <= NCH; k++) begin
      if (k > 0 && k - 1 < d.size())
        for (int ch = 0; ch < NCH; ch++) if (val[ch] == d[k-1]) m[ch] = 1'b0;
      tbl[4*k]     = m[7:0];
      tbl[4*k + 1] = m[15:8];
      tbl[4*k + 2] = (k < d.size()) ? 8'(d[k]) : 8'h00;
      tbl[4*k + 3] = (k < d.size()) ? 8'h01 : 8'h00;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_idx = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (m_idx == NB - 1) begin m_busy = 1'b0; m_done = 1'b1; end
        else m_idx++;
      end else if (start) begin
        build(levels);
        m_busy = 1'b1;
        m_idx  = 0;
      end
    end
  end

  task automatic cmp(input string rq, input int act, input int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    n_vec++;
    cmp({tag, "/R1,R2 wr_en"}, int'(wr_en), int'(m_busy));
    cmp({tag, "/R8 done"}, int'(done), int'(m_done));
    if (m_busy && wr_en) begin
      cmp({tag, "/R2 wr_addr"}, int'(wr_addr), m_idx);
      if (m_idx % 4 < 2)
        cmp({tag, (m_idx < 4) ? "/R3,R4 mask byte" : "/R3,R5 mask byte"}, int'(wr_data), int'(tbl[m_idx]));
      else
        cmp({tag, "/R3,R6 cmp/flag byte"}, int'(wr_data), int'(tbl[m_idx]));
    end
  end

  task automatic kick(input logic [NCH*8-1:0] v);
    levels = v;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_done();
    while (!m_done) @(negedge clk);
  endtask

  task automatic run(input string t, input logic [NCH*8-1:0] v);
    tag = t;
    kick(v);
    wait_done();
  endtask

  function automatic logic [NCH*8-1:0] mk(input int sel, input int seed);
    logic [NCH*8-1:0] r;
    int s = seed;
    for (int i = 0; i < NCH; i++) begin
      case (sel)
        0: r[8*i +: 8] = 8'(i * 16 + 1);
        1: r[8*i +: 8] = (i < 8) ? 8'd10 : 8'd200;
        2: r[8*i +: 8] = (i % 2 == 0) ? 8'd0 : 8'(i * 7);
        3: r[8*i +: 8] = (i % 3 == 0) ? 8'd5 : ((i % 3 == 1) ? 8'd9 : 8'd5);
        4: r[8*i +: 8] = (i % 3 == 0) ? 8'hFF : 8'(i * 3 + 1);
        5: r[8*i +: 8] = 8'hFF;
        6: r[8*i +: 8] = 8'h00;
        7: r[8*i +: 8] = (i == 4) ? 8'd77 : 8'd0;
        default: begin
          s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
          r[8*i +: 8] = (s[3:0] == 4'd0) ? 8'd0 : ((s[3:0] == 4'd1) ? 8'hFF : 8'(s[11:4] & 8'h1F));
        end
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run("R11", mk(0, 0));
    run("R3", mk(1, 0));
    run("R4", mk(2, 0));
    run("R5", mk(3, 0));
    repeat (2) @(negedge clk);
    run("R7", mk(4, 0));
    run("R7", mk(5, 0));
    run("R4", mk(6, 0));
    run("R6", mk(7, 0));
    // R9: start pulses during a build, new levels alongside
    tag = "R9";
    kick(mk(3, 0));
    repeat (20) @(negedge clk);
    kick(mk(0, 0));
    repeat (30) @(negedge clk);
    kick(mk(5, 0));
    wait_done();
    // R10: level bank changes mid-build without a start
    tag = "R10";
    kick(mk(4, 0));
    repeat (9) @(negedge clk);
    levels = mk(6, 0);
    repeat (25) @(negedge clk);
    levels = mk(1, 0);
    wait_done();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) run("R6", mk(8, 12345 + k * 977));
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule